// File: doc/BRIEF.md
# Legacy PCI Interrupt Router with Software-Routing Detection

This block steers the four legacy interrupt pins (INTA..INTD) of every PCI slot onto four system interrupt lines. Two routings exist. The correct one rotates each pin by the slot number plus a fixed offset for the board. The old direct one sends pin n of every slot to line n, and some older system software still expects it. The block works out which routing software expects. It looks at the first configuration write that lands on an interrupt-line register and judges the value written. After that it keeps its decision until the next reset.

The block only monitors configuration writes and does not store them. Device interrupt levels arrive as update strobes, each carrying a slot, a pin and a level. The block keeps one level bit for each slot and pin. When the mode changes, interrupts that are already asserted move to their new lines at once. A board strap selects the alternate board, whose rotation offset differs and which never runs detection. A mode strap sets the mode loaded at reset.

Top module: `pci_irq_router`

## Requirements
- R1: While reset is asserted, `mode` loads from `mode_strap` (0 = assume-ok, 1 = broken, 2 = force-ok, 3 is treated as assume-ok). All stored levels clear, so `irq_out` is 0 after reset.
- R2: Once `mode` is broken (1) or force-ok (2), no configuration write changes it until the next reset.
- R3: Detection fires only on a cycle with `cfg_wr` high and `cfg_addr[7:0]` equal to 0x3C. The slot is `cfg_addr[15:11]`, and only its value modulo 4 is used. Writes to any other offset leave `mode` unchanged.
- R4: A detected write of 27 keeps assume-ok when slot mod 4 is 2. In every other slot it sets broken.
- R5: A detected write equal to 27 + (slot mod 4), or to 91 + (slot mod 4), sets broken. Any other 8-bit value sets force-ok.
- R6: In broken mode, pin n (0 = INTA .. 3 = INTD) of any slot drives `irq_out[n]`.
- R7: Outside broken mode, pin p of slot s drives `irq_out[(s + p + 2) mod 4]` when `board_alt` = 0. It drives `irq_out[(s + p + 3) mod 4]` when `board_alt` = 1.
- R8: With `board_alt` = 1, configuration writes never change `mode`.
- R9: Each output is the OR of all stored slot/pin levels routed to it. A level stays stored until a later update clears it, and a mode change re-routes stored levels.
- R10: A mode decision and a level update are both taken at the clock edge that samples the strobe. Both are visible on the outputs right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_addr | input | ADDR_W | Configuration address: [15:8] device/function, [7:0] register offset |
| cfg_wdata | input | 8 | Low byte of the configuration write data |
| irq_upd | input | 1 | Interrupt level update strobe |
| irq_slot | input | SLOT_W | Slot of the update |
| irq_pin | input | 2 | Pin of the update (0 = INTA .. 3 = INTD) |
| irq_level | input | 1 | New level of that slot/pin |
| board_alt | input | 1 | Board strap: 0 primary, 1 alternate |
| mode_strap | input | 2 | Mode loaded during reset |
| irq_out | output | 4 | System interrupt lines |
| mode | output | 2 | Current routing mode |

## Verification
Detection is tried with the value 27 in a slot where it is ambiguous and in one where it is not. It is also tried with both rotated-broken value families, with a neutral value, and with the right value at the wrong register offset. Together these separate the three verdicts and show that the trigger depends on the offset. Routing is tried with two sources that share one output line, with one source released while the other holds, and with pins held across a change to broken mode. These separate OR behaviour from last-writer behaviour and show that stored levels are re-routed. Each mode strap value is covered, and the alternate board strap is run in both assume-ok and broken modes.

// File: rtl/pci_irq_router.sv
module pci_irq_router #(
  parameter int          NUM_SLOTS = 32,
  parameter int          SLOT_W    = 5,
  parameter int          ADDR_W    = 24,
  parameter logic [7:0]  LINE_OFS  = 8'h3C,
  parameter int          BASE_IRQ  = 27,
  parameter int          LATE_OFS  = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [ADDR_W-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic              irq_upd,
  input  logic [SLOT_W-1:0] irq_slot,
  input  logic [1:0]        irq_pin,
  input  logic              irq_level,
  input  logic              board_alt,
  input  logic [1:0]        mode_strap,
  output logic [3:0]        irq_out,
  output logic [1:0]        mode
);
  localparam logic [1:0] M_ASSUME = 2'd0;
  localparam logic [1:0] M_BROKEN = 2'd1;
  localparam logic [1:0] M_FORCE  = 2'd2;
  localparam logic [7:0] V_BASE   = 8'(BASE_IRQ);
  localparam logic [7:0] V_LATE   = 8'(BASE_IRQ + LATE_OFS);

  logic [NUM_SLOTS-1:0][3:0] lvl;
  logic [1:0] wslot, verdict, strap_mode;
  logic       hit;

  assign wslot      = cfg_addr[12:11];
  assign hit        = cfg_wr && !board_alt && (mode == M_ASSUME) && (cfg_addr[7:0] == LINE_OFS);
  assign strap_mode = (mode_strap == 2'd3) ? M_ASSUME : mode_strap;

  always_comb begin
    if (cfg_wdata == V_BASE)
      verdict = (wslot == 2'd2) ? M_ASSUME : M_BROKEN;
    else if (cfg_wdata == V_BASE + {6'd0, wslot} || cfg_wdata == V_LATE + {6'd0, wslot})
      verdict = M_BROKEN;
    else
      verdict = M_FORCE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode <= strap_mode;
    else if (hit) mode <= verdict;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) lvl <= '0;
    else if (irq_upd && (int'(irq_slot) < NUM_SLOTS)) lvl[irq_slot][irq_pin] <= irq_level;
  end

  always_comb begin
    irq_out = '0;
    for (int s = 0; s < NUM_SLOTS; s++)
      for (int p = 0; p < 4; p++)
        if (lvl[s][p]) begin
          if (mode == M_BROKEN) irq_out[2'(p)] = 1'b1;
          else irq_out[2'(s) + 2'(p) + (board_alt ? 2'd3 : 2'd2)] = 1'b1;
        end
  end
endmodule

module pci_irq_router_chk #(
  parameter int         ADDR_W   = 24,
  parameter logic [7:0] LINE_OFS = 8'h3C
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_wr,
  input logic [ADDR_W-1:0] cfg_addr,
  input logic [7:0]        cfg_wdata,
  input logic              board_alt,
  input logic [1:0]        mode
);
  AST_MODE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (mode != 2'd0) |=> $stable(mode)); // R2
  AST_ALT_NO_DETECT: assert property (@(posedge clk) disable iff (!rst_n)
    (board_alt && mode == 2'd0) |=> (mode == 2'd0)); // R8
  AST_OFFSET_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    !(cfg_wr && cfg_addr[7:0] == LINE_OFS) |=> $stable(mode)); // R3
  AST_NEUTRAL_FORCE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_addr[7:0] == LINE_OFS && !board_alt && mode == 2'd0 && cfg_wdata == 8'h20)
    |=> (mode == 2'd2)); // R5
  AST_MODE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'd3); // R1
endmodule

bind pci_irq_router pci_irq_router_chk #(.ADDR_W(ADDR_W), .LINE_OFS(LINE_OFS)) chk_i (.*);

// File: tb/pci_irq_router_tb.sv
module pci_irq_router_tb_top;
  logic clk = 0, rst_n = 0, cfg_wr = 0, irq_upd = 0, irq_level = 0, board_alt = 0;
  logic [23:0] cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic [4:0]  irq_slot = '0;
  logic [1:0]  irq_pin = '0, mode_strap = '0, mode;
  logic [3:0]  irq_out;
  int errs = 0, checks = 0;
  string cur_req = "R1";

  always #10 clk = ~clk;

  pci_irq_router dut_i (.*);

  int m_mode;
  int m_lvl [32][4];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = (mode_strap == 2'd3) ? 0 : int'(mode_strap);
      foreach (m_lvl[s, p]) m_lvl[s][p] = 0;
    end else begin
      if (irq_upd) m_lvl[irq_slot][irq_pin] = int'(irq_level);
      if (cfg_wr && !board_alt && m_mode == 0 && cfg_addr[7:0] == 8'h3C) begin
        int s, v;
        s = (int'(cfg_addr) >> 11) % 4;
        v = int'(cfg_wdata);
        if (v == 27) m_mode = (s == 2) ? 0 : 1;
        else if (v == 27 + s || v == 91 + s) m_mode = 1;
        else m_mode = 2;
      end
    end
  end

  function automatic int exp_out();
    int o = 0;
    for (int s = 0; s < 32; s++)
      for (int p = 0; p < 4; p++)
        if (m_lvl[s][p] != 0)
          o |= 1 << ((m_mode == 1) ? p : (s + p + (board_alt ? 3 : 2)) % 4);
    return o;
  endfunction

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(cur_req, "model mode", int'(mode), m_mode);
    chk(cur_req, "model irq_out", int'(irq_out), exp_out());
  end

  task automatic do_rst(input logic [1:0] st, input logic alt);
    rst_n = 0; mode_strap = st; board_alt = alt;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic cfgw(input int slot, input logic [7:0] ofs, input int val);
    cfg_addr = {8'h5A, 5'(slot), 3'd1, ofs};
    cfg_wdata = 8'(val); cfg_wr = 1;
    @(negedge clk);
    cfg_wr = 0;
  endtask

  task automatic irq(input int slot, input int pin, input logic lv);
    irq_slot = 5'(slot); irq_pin = 2'(pin); irq_level = lv; irq_upd = 1;
    @(negedge clk);
    irq_upd = 0;
  endtask

  initial begin
    #(20 * 150000);
    errs++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    cur_req = "R1"; do_rst(0, 0);
    chk("R1", "reset mode", int'(mode), 0);
    chk("R1", "reset out", int'(irq_out), 0);
    cur_req = "R7";
    irq(1, 0, 1); chk("R7", "slot1 INTA", int'(irq_out), 8);
    irq(5, 3, 1); chk("R10", "slot5 INTD", int'(irq_out), 12);
    cur_req = "R9";
    irq(0, 1, 1); irq(1, 0, 0); chk("R9", "shared line held", int'(irq_out), 12);
    irq(0, 1, 0); chk("R9", "shared line released", int'(irq_out), 4);
    irq(1, 0, 1);
    cur_req = "R3";
    cfgw(0, 8'h3D, 27); chk("R3", "wrong offset", int'(mode), 0);
    cur_req = "R4";
    cfgw(2, 8'h3C, 27); chk("R4", "27 in slot2", int'(mode), 0);
    cfgw(0, 8'h3C, 27); chk("R4", "27 in slot0", int'(mode), 1);
    chk("R10", "mode next cycle", int'(mode), 1);
    chk("R6", "broken reroute", int'(irq_out), 9);
    cur_req = "R2";
    cfgw(1, 8'h3C, 8'h55); chk("R2", "broken sticky", int'(mode), 1);
    cur_req = "R5";
    do_rst(0, 0); chk("R1", "levels cleared", int'(irq_out), 0);
    cfgw(3, 8'h3C, 30); chk("R5", "slot+27", int'(mode), 1);
    do_rst(0, 0); cfgw(1, 8'h3C, 92); chk("R5", "slot+91", int'(mode), 1);
    do_rst(0, 0); cfgw(6, 8'h3C, 64); chk("R5", "neutral value", int'(mode), 2);
    cur_req = "R2";
    cfgw(0, 8'h3C, 27); chk("R2", "force sticky", int'(mode), 2);
    cur_req = "R7";
    irq(3, 1, 1); chk("R7", "force-ok routing", int'(irq_out), 4);
    cur_req = "R1";
    do_rst(1, 0); chk("R1", "strap 1", int'(mode), 1);
    do_rst(2, 0); chk("R1", "strap 2", int'(mode), 2);
    do_rst(3, 0); chk("R1", "strap 3", int'(mode), 0);
    cur_req = "R8";
    do_rst(0, 1);
    cfgw(0, 8'h3C, 27); chk("R8", "alt 27", int'(mode), 0);
    cfgw(1, 8'h3C, 8'h55); chk("R8", "alt neutral", int'(mode), 0);
    cur_req = "R7";
    irq(0, 0, 1); chk("R7", "alt slot0 INTA", int'(irq_out), 8);
    irq(31, 2, 1); chk("R7", "alt slot31 INTC", int'(irq_out), 9);
    cur_req = "R6";
    do_rst(1, 1); irq(2, 2, 1); chk("R6", "alt broken direct", int'(irq_out), 4);
    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule